// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block turns virtual addresses into physical addresses for a core. It is a small, fully associative cache of page translations and answers in the same cycle that a request is presented. Each entry covers one 8 KB page. An entry records the virtual page, the owning address-space identifier, the physical frame, and three permission bits: read allowed, write allowed and user allowed. Because entries carry the identifier, a context switch needs no flush: a lookup only matches entries whose page and identifier both equal the request.

A lookup returns exactly one of three outcomes. A hit returns a physical address. A miss means the walker must supply a translation. A fault means a translation exists but the access type or privilege mode is not allowed. A hardwired kernel window needs no entry at all. Any address whose top bit is 1 and whose next bit is 0 is a kernel window address. Its physical address is simply its low address bits, and it is reachable only from kernel mode.

The miss handler loads translations through a refill port. A refill either overwrites the matching entry or takes a round-robin victim that is never a pinned entry. Maintenance inputs remove the entry for one page, or clear every entry that is not pinned.

Top module: `xlat_tlb`

## Requirements
- R1: A lookup of a valid entry whose page and address-space ID both match, with permissions allowed, raises hit in the same cycle. The physical address is the entry's frame number above the 13 untouched offset bits.
- R2: An entry never matches a lookup carrying a different address-space ID. The same virtual page may be held under two IDs, each with its own frame.
- R3: Permission check. A write needs the write bit and a read needs the read bit. User mode (lk_user_i=1) also needs the user bit. A failed check gives fault with hit low and address zero.
- R4: A kernel window address (lk_va_i[63]=1, lk_va_i[62]=0) bypasses the array. In kernel mode it hits with address lk_va_i[PA_W-1:0]. In user mode it faults. It never misses.
- R5: With lk_valid_i low, hit, miss and fault are all low. At most one of the three is ever high.
- R6: An invalidate clears the entry matching its page and ID, even if that entry is pinned. Other entries are kept.
- R7: A flush clears, in one cycle, every entry that is not pinned. Pinned entries keep translating.
- R8: Victim choice. A refill whose page and ID already exist rewrites that entry and leaves the pointer in place. Any other refill takes the first unpinned slot found circularly from the pointer, then moves the pointer to the slot after it.
- R9: If every slot is pinned, a refill for a new page is dropped. full_err_o then rises and stays high until reset.
- R10: When a lookup and a refill of the same page happen in the same cycle, the lookup misses. The translation hits from the next cycle on.
- R11: After reset, no entry is valid, full_err_o is low and the victim pointer is at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_write_i | input | 1 | 1 = write access, 0 = read access |
| lk_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| lk_asid_i | input | ASID_W | Current address-space ID |
| lk_hit_o | output | 1 | Translation valid |
| lk_miss_o | output | 1 | No translation held |
| lk_fault_o | output | 1 | Access or mode violation |
| lk_pa_o | output | PA_W | Physical address on hit, else zero |
| fill_valid_i | input | 1 | Refill request |
| fill_vpn_i | input | VA_W-13 | Refill virtual page number |
| fill_asid_i | input | ASID_W | Refill address-space ID |
| fill_pfn_i | input | PA_W-13 | Refill physical frame number |
| fill_rd_i | input | 1 | Refill read permission |
| fill_wr_i | input | 1 | Refill write permission |
| fill_usr_i | input | 1 | Refill user-access permission |
| fill_pin_i | input | 1 | Pin the refilled entry |
| inv_valid_i | input | 1 | Invalidate one page |
| inv_vpn_i | input | VA_W-13 | Page to invalidate |
| inv_asid_i | input | ASID_W | ID of page to invalidate |
| flush_i | input | 1 | Clear all unpinned entries |
| full_err_o | output | 1 | Sticky: refill dropped because every slot was pinned |

## Verification
The bench builds the block with ENTRIES=4, PA_W=32 and ASID_W=4, keeping the 64-bit virtual address. With four slots, a handful of refills is enough to wrap the victim pointer around pinned slots. It also pushes the cache into the all-pinned state, where the refill is dropped and the error flag becomes sticky. The narrow physical address makes the kernel window translation a plain truncation, so the expected value is easy to state. It also still exercises both window-decode bits.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PG_OFF_W = 13;

  typedef struct packed {
    logic usr;
    logic wr;
    logic rd;
  } perm_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N      = 48,
  parameter int VPN_W  = 51,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 31,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N-1:0]               valid_i,
  input  logic [N-1:0][VPN_W-1:0]    vpn_i,
  input  logic [N-1:0][ASID_W-1:0]   asid_i,
  input  logic [N-1:0][PFN_W-1:0]    pfn_i,
  input  xlat_pkg::perm_t [N-1:0]    perm_i,
  input  logic [VPN_W-1:0]           key_vpn_i,
  input  logic [ASID_W-1:0]          key_asid_i,
  output logic                       hit_o,
  output logic [N-1:0]               vec_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [PFN_W-1:0]           pfn_o,
  output xlat_pkg::perm_t            perm_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign vec_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end

  assign hit_o = |vec_o;

  // one-hot select: entries never duplicate, so OR-merge is exact
  always_comb begin
    logic [2:0] pm;
    pfn_o = '0;
    idx_o = '0;
    pm    = '0;
    for (int i = 0; i < N; i++) begin
      if (vec_o[i]) begin
        pfn_o = pfn_o | pfn_i[i];
        pm    = pm | perm_i[i];
        idx_o = idx_o | IDX_W'(i);
      end
    end
    perm_o = xlat_pkg::perm_t'(pm);
  end

  // R8
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(vec_o));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 48,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     pin_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             none_o
);
  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    none_o   = 1'b1;
    victim_o = ptr_q;
    for (int k = 0; k < N; k++) begin
      int slot;
      slot = int'(ptr_q) + k;
      if (slot >= N) slot = slot - N;
      if (none_o && !pin_i[slot]) begin
        victim_o = IDX_W'(slot);
        none_o   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (adv_i) ptr_q <= (int'(victim_o) == N-1) ? '0 : victim_o + 1'b1;
  end

  // R8
  victim_unpinned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !none_o |-> !pin_i[victim_o]);
  // R8
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) int'(ptr_q) < N);
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int ENTRIES = 48,
  parameter int VA_W    = 64,
  parameter int PA_W    = 44,
  parameter int ASID_W  = 8,
  localparam int OFF_W  = xlat_pkg::PG_OFF_W,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PFN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic              lk_write_i,
  input  logic              lk_user_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_fault_o,
  output logic [PA_W-1:0]   lk_pa_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_rd_i,
  input  logic              fill_wr_i,
  input  logic              fill_usr_i,
  input  logic              fill_pin_i,
  input  logic              inv_valid_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic              flush_i,
  output logic              full_err_o
);
  logic [ENTRIES-1:0]             valid_q, pin_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  xlat_pkg::perm_t [ENTRIES-1:0]  perm_q;

  // lookup
  logic                 l_hit;
  logic [ENTRIES-1:0]   l_vec;
  logic [IDX_W-1:0]     l_idx;
  logic [PFN_W-1:0]     l_pfn;
  xlat_pkg::perm_t      l_perm;

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_lk_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q), .pfn_i(pfn_q),
    .perm_i(perm_q), .key_vpn_i(lk_va_i[VA_W-1:OFF_W]), .key_asid_i(lk_asid_i),
    .hit_o(l_hit), .vec_o(l_vec), .idx_o(l_idx), .pfn_o(l_pfn), .perm_o(l_perm));

  logic kseg, perm_ok;
  assign kseg    = lk_va_i[VA_W-1] & ~lk_va_i[VA_W-2];
  assign perm_ok = (lk_write_i ? l_perm.wr : l_perm.rd) & (~lk_user_i | l_perm.usr);

  always_comb begin
    lk_hit_o   = 1'b0;
    lk_miss_o  = 1'b0;
    lk_fault_o = 1'b0;
    lk_pa_o    = '0;
    if (lk_valid_i) begin
      if (kseg) begin
        if (lk_user_i) lk_fault_o = 1'b1;
        else begin
          lk_hit_o = 1'b1;
          lk_pa_o  = lk_va_i[PA_W-1:0];
        end
      end else if (l_hit) begin
        if (perm_ok) begin
          lk_hit_o = 1'b1;
          lk_pa_o  = {l_pfn, lk_va_i[OFF_W-1:0]};
        end else lk_fault_o = 1'b1;
      end else lk_miss_o = 1'b1;
    end
  end

  // refill
  logic                 f_hit;
  logic [ENTRIES-1:0]   f_vec;
  logic [IDX_W-1:0]     f_idx;
  logic [PFN_W-1:0]     f_pfn;
  xlat_pkg::perm_t      f_perm;

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_fill_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q), .pfn_i(pfn_q),
    .perm_i(perm_q), .key_vpn_i(fill_vpn_i), .key_asid_i(fill_asid_i),
    .hit_o(f_hit), .vec_o(f_vec), .idx_o(f_idx), .pfn_o(f_pfn), .perm_o(f_perm));

  logic [IDX_W-1:0] victim, fill_idx;
  logic             none_free, fill_we, fill_adv;

  assign fill_adv = fill_valid_i & ~f_hit & ~none_free;
  assign fill_we  = fill_valid_i & (f_hit | ~none_free);
  assign fill_idx = f_hit ? f_idx : victim;

  xlat_victim #(.N(ENTRIES)) u_victim (
    .clk_i, .rst_ni, .pin_i(pin_q), .adv_i(fill_adv), .victim_o(victim), .none_o(none_free));

  // invalidate
  logic                 i_hit;
  logic [ENTRIES-1:0]   i_vec;
  logic [IDX_W-1:0]     i_idx;
  logic [PFN_W-1:0]     i_pfn;
  xlat_pkg::perm_t      i_perm;

  xlat_match #(.N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_inv_match (
    .clk_i, .rst_ni, .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q), .pfn_i(pfn_q),
    .perm_i(perm_q), .key_vpn_i(inv_vpn_i), .key_asid_i(inv_asid_i),
    .hit_o(i_hit), .vec_o(i_vec), .idx_o(i_idx), .pfn_o(i_pfn), .perm_o(i_perm));

  // state: clears first, refill write wins its own slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= '0;
      pin_q      <= '0;
      full_err_o <= 1'b0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (flush_i && !pin_q[i]) valid_q[i] <= 1'b0;
        if (inv_valid_i && i_vec[i]) begin
          valid_q[i] <= 1'b0;
          pin_q[i]   <= 1'b0;
        end
        if (fill_we && int'(fill_idx) == i) begin
          valid_q[i] <= 1'b1;
          pin_q[i]   <= fill_pin_i;
        end
      end
      if (fill_valid_i && !f_hit && none_free) full_err_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we) begin
      vpn_q[fill_idx]  <= fill_vpn_i;
      asid_q[fill_idx] <= fill_asid_i;
      pfn_q[fill_idx]  <= fill_pfn_i;
      perm_q[fill_idx] <= '{usr: fill_usr_i, wr: fill_wr_i, rd: fill_rd_i};
    end
  end

  // R1
  hit_offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_pa_o[OFF_W-1:0] == lk_va_i[OFF_W-1:0]);
  // R4
  kseg_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_user_i && lk_va_i[VA_W-1] && !lk_va_i[VA_W-2]) |-> lk_fault_o);
  // R5
  outcome_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lk_hit_o, lk_miss_o, lk_fault_o}) && (lk_valid_i || !(lk_hit_o || lk_miss_o || lk_fault_o)));
  // R6
  inv_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && !fill_valid_i) |=> (valid_q & $past(i_vec)) == '0);
  // R7
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !fill_valid_i) |=> (valid_q & ~pin_q) == '0);
  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_err_o |=> full_err_o);
  // R10
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we |=> valid_q[$past(fill_idx)]);
endmodule

// File: tb/xlat_tlb_test.sv
module xlat_tlb_test;
  localparam int N = 4, VA_W = 64, PA_W = 32, ASID_W = 4;
  localparam int VPN_W = VA_W - 13, PFN_W = PA_W - 13;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic lk_valid_i, lk_write_i, lk_user_i;
  logic [VA_W-1:0] lk_va_i;
  logic [ASID_W-1:0] lk_asid_i;
  logic lk_hit_o, lk_miss_o, lk_fault_o, full_err_o;
  logic [PA_W-1:0] lk_pa_o;
  logic fill_valid_i, fill_rd_i, fill_wr_i, fill_usr_i, fill_pin_i;
  logic [VPN_W-1:0] fill_vpn_i, inv_vpn_i;
  logic [ASID_W-1:0] fill_asid_i, inv_asid_i;
  logic [PFN_W-1:0] fill_pfn_i;
  logic inv_valid_i, flush_i;

  always #4 clk = ~clk;

  xlat_tlb #(.ENTRIES(N), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) uut (
    .clk_i(clk), .rst_ni, .lk_valid_i, .lk_va_i, .lk_write_i, .lk_user_i, .lk_asid_i,
    .lk_hit_o, .lk_miss_o, .lk_fault_o, .lk_pa_o, .fill_valid_i, .fill_vpn_i, .fill_asid_i,
    .fill_pfn_i, .fill_rd_i, .fill_wr_i, .fill_usr_i, .fill_pin_i, .inv_valid_i, .inv_vpn_i,
    .inv_asid_i, .flush_i, .full_err_o);

  typedef struct {
    logic hit, miss, fault, err;
    logic [PA_W-1:0] pa;
    string req;
  } exp_t;
  exp_t exp_q[$];
  int checks = 0, errors = 0;
  logic exp_err = 1'b0;
  bit done = 0;

  function automatic logic [VA_W-1:0] mk_va(logic [VPN_W-1:0] vpn);
    return {vpn, 13'h0abc};
  endfunction
  function automatic logic [PA_W-1:0] mk_pa(logic [PFN_W-1:0] pfn);
    return {pfn, 13'h0abc};
  endfunction

  task automatic clear_in();
    lk_valid_i = 0; lk_va_i = '0; lk_write_i = 0; lk_user_i = 0; lk_asid_i = '0;
    fill_valid_i = 0; fill_vpn_i = '0; fill_asid_i = '0; fill_pfn_i = '0;
    fill_rd_i = 0; fill_wr_i = 0; fill_usr_i = 0; fill_pin_i = 0;
    inv_valid_i = 0; inv_vpn_i = '0; inv_asid_i = '0; flush_i = 0;
  endtask

  task automatic set_lk(logic v, logic [VA_W-1:0] va, logic [ASID_W-1:0] asid, logic wr, logic usr,
                        logic h, logic m, logic f, logic [PA_W-1:0] pa, string req);
    exp_t e;
    lk_valid_i = v; lk_va_i = va; lk_asid_i = asid; lk_write_i = wr; lk_user_i = usr;
    e.hit = h; e.miss = m; e.fault = f; e.pa = h ? pa : '0; e.err = exp_err; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic lookup(logic [VA_W-1:0] va, logic [ASID_W-1:0] asid, logic wr, logic usr,
                        logic h, logic m, logic f, logic [PA_W-1:0] pa, string req);
    @(negedge clk); clear_in();
    set_lk(1'b1, va, asid, wr, usr, h, m, f, pa, req);
  endtask

  task automatic hit_u(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid, logic [PFN_W-1:0] pfn, string req);
    lookup(mk_va(vpn), asid, 0, 1, 1, 0, 0, mk_pa(pfn), req);
  endtask
  task automatic miss_u(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid, string req);
    lookup(mk_va(vpn), asid, 0, 1, 0, 1, 0, '0, req);
  endtask

  task automatic set_fill(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid, logic [PFN_W-1:0] pfn,
                          logic rd, logic wr, logic usr, logic pin);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_asid_i = asid; fill_pfn_i = pfn;
    fill_rd_i = rd; fill_wr_i = wr; fill_usr_i = usr; fill_pin_i = pin;
  endtask
  task automatic fill(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid, logic [PFN_W-1:0] pfn,
                      logic rd, logic wr, logic usr, logic pin);
    @(negedge clk); clear_in();
    set_fill(vpn, asid, pfn, rd, wr, usr, pin);
  endtask
  task automatic inval(logic [VPN_W-1:0] vpn, logic [ASID_W-1:0] asid);
    @(negedge clk); clear_in();
    inv_valid_i = 1; inv_vpn_i = vpn; inv_asid_i = asid;
  endtask
  task automatic flush();
    @(negedge clk); clear_in();
    flush_i = 1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare scoreboard items away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (lk_hit_o !== e.hit || lk_miss_o !== e.miss || lk_fault_o !== e.fault ||
            lk_pa_o !== e.pa || full_err_o !== e.err) begin
          errors++;
          $display("FAIL %s: got hit=%b miss=%b fault=%b pa=%h err=%b, expected hit=%b miss=%b fault=%b pa=%h err=%b",
                   e.req, lk_hit_o, lk_miss_o, lk_fault_o, lk_pa_o, full_err_o,
                   e.hit, e.miss, e.fault, e.pa, e.err);
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  localparam logic [VPN_W-1:0] VA_A = 'h10, VA_B = 'h20, VA_C = 'h30, VA_D = 'h40,
    VA_E = 'h50, VA_F = 'h60, VA_G = 'h70, VA_H = 'h80, VA_I = 'h90;
  localparam logic [VA_W-1:0] KVA = 64'h8000_0000_1234_5678;

  initial begin
    clear_in();
    #3;
    checks++;
    if (full_err_o !== 1'b0 || lk_hit_o !== 1'b0) begin
      errors++;
      $display("FAIL R11: got err=%b hit=%b, expected err=0 hit=0", full_err_o, lk_hit_o);
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    miss_u(VA_A, 1, "R11 empty after reset");
    fill(VA_A, 1, 'h111, 1, 1, 1, 0);
    hit_u(VA_A, 1, 'h111, "R1 basic hit");
    lookup(mk_va(VA_A), 1, 1, 1, 1, 0, 0, mk_pa('h111), "R1 write hit");
    miss_u(VA_A, 2, "R2 other asid misses");
    fill(VA_A, 2, 'h222, 1, 0, 0, 0);
    lookup(mk_va(VA_A), 2, 0, 0, 1, 0, 0, mk_pa('h222), "R2 same page other asid");
    hit_u(VA_A, 1, 'h111, "R2 first asid intact");
    lookup(mk_va(VA_A), 2, 1, 0, 0, 0, 1, '0, "R3 write without write bit");
    lookup(mk_va(VA_A), 2, 0, 1, 0, 0, 1, '0, "R3 user without user bit");
    lookup(KVA, 3, 0, 0, 1, 0, 0, 32'h1234_5678, "R4 kernel window kernel");
    lookup(KVA, 3, 1, 1, 0, 0, 1, '0, "R4 kernel window user");
    @(negedge clk); clear_in();
    set_lk(1'b0, mk_va(VA_A), 1, 0, 1, 0, 0, 0, '0, "R5 idle lookup");

    // R10: same-cycle refill and lookup
    @(negedge clk); clear_in();
    set_fill(VA_B, 1, 'h333, 1, 1, 1, 0);
    set_lk(1'b1, mk_va(VA_B), 1, 0, 1, 0, 1, 0, '0, "R10 same cycle miss");
    hit_u(VA_B, 1, 'h333, "R10 next cycle hit");

    // R8: in-place rewrite, pointer unchanged (slot 3 next)
    fill(VA_A, 1, 'h444, 1, 1, 1, 0);
    hit_u(VA_A, 1, 'h444, "R8 rewrite in place");
    lookup(mk_va(VA_A), 2, 0, 0, 1, 0, 0, mk_pa('h222), "R8 other entry kept");
    hit_u(VA_B, 1, 'h333, "R8 third entry kept");

    inval(VA_A, 1);
    miss_u(VA_A, 1, "R6 invalidated");
    lookup(mk_va(VA_A), 2, 0, 0, 1, 0, 0, mk_pa('h222), "R6 neighbour kept");

    fill(VA_C, 1, 'h555, 1, 1, 1, 1);
    hit_u(VA_C, 1, 'h555, "R8 pinned fill");
    flush();
    hit_u(VA_C, 1, 'h555, "R7 pinned survives flush");
    lookup(mk_va(VA_A), 2, 0, 0, 0, 1, 0, '0, "R7 unpinned flushed");
    miss_u(VA_B, 1, "R7 unpinned flushed");

    // C pinned in slot 3, pointer at 0
    fill(VA_D, 1, 'h561, 1, 1, 1, 0);
    fill(VA_E, 1, 'h562, 1, 1, 1, 1);
    fill(VA_F, 1, 'h563, 1, 1, 1, 1);
    fill(VA_G, 1, 'h564, 1, 1, 1, 0);
    miss_u(VA_D, 1, "R8 skip pinned evicts D");
    hit_u(VA_G, 1, 'h564, "R8 G placed");
    hit_u(VA_E, 1, 'h562, "R8 E kept");
    hit_u(VA_F, 1, 'h563, "R8 F kept");
    hit_u(VA_C, 1, 'h555, "R8 C kept");
    fill(VA_H, 1, 'h565, 1, 1, 1, 1);
    miss_u(VA_G, 1, "R8 G evicted by H");
    hit_u(VA_H, 1, 'h565, "R8 H placed");

    fill(VA_I, 1, 'h566, 1, 1, 1, 0);
    exp_err = 1'b1;
    miss_u(VA_I, 1, "R9 refill dropped");
    hit_u(VA_C, 1, 'h555, "R9 pinned intact");
    hit_u(VA_E, 1, 'h562, "R9 pinned intact");
    inval(VA_H, 1);
    miss_u(VA_H, 1, "R6 pinned invalidated");
    hit_u(VA_F, 1, 'h563, "R9 error stays set");

    @(negedge clk); clear_in();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule